// File: doc/BRIEF.md
# Two-Wire Converter Result Reader

This block is the host side of a two-wire link to a delta-sigma converter whose chip select is tied low. The converter uses its serial data line as a status line: the line sits high while a conversion runs and drops low once the result is ready and the converter is asleep. The reader polls that level, or an optional busy line that carries the same information. When the converter reports ready, the reader generates a serial clock from the system clock and shifts in a 32-bit frame.

The converter changes its data line on each falling serial clock edge, so the reader samples on each rising edge. The first bit taken is the end-of-conversion flag, which lands in frame bit 31. The remaining bits follow MSB first, down to bit 0. After exactly 32 rising edges the clock stays low, because the 32nd falling edge starts the next conversion. The captured word is then presented with a one-cycle strobe, and the reader goes back to polling.

An error flag marks frames whose leading flag bit is not 0. A timeout flag reports a converter that has not become ready within a set number of system clock cycles.

Top module: `twowire_result_reader`

## Requirements
- R1: While reset is asserted, and right after it, `sckOut`, `frameValid`, `frameErr` and `timeoutFlag` are 0 and `frameData` is all zeros.
- R2: While no frame is open and the selected ready line reads 1 (converter busy), `sckOut` produces no rising edge.
- R3: The ready line is `sdoIn` when `selBusy` is 0 and `busyIn` when `selBusy` is 1. A level of 0 on that line means the result is ready.
- R4: Every low phase of `sckOut` lasts at least `HALF_DIV` system clock cycles. This includes the low time between detecting ready and the first rising edge. Each high phase lasts `HALF_DIV` cycles.
- R5: Each frame has exactly `FRAME_BITS` (32) rising edges of `sckOut`. The clock then stays low and the reader returns to polling.
- R6: `sdoIn` is sampled at each rising edge of `sckOut`. The first sample becomes `frameData[31]`, and each later sample goes into the next lower bit, so the last one becomes `frameData[0]`.
- R7: `frameValid` is high for exactly one system clock cycle per frame. `frameData` holds the frame until the next one.
- R8: `frameErr` is updated together with `frameData`. It is 1 when the captured bit 31 was 1 and 0 otherwise.
- R9: `timeoutFlag` rises after `TIMEOUT_CYC` consecutive polling cycles with the ready line at 1. It stays set while polling continues and clears when ready is detected or the reader goes idle.
- R10: With `enable` low, the reader stays idle and drives no clock edge. Dropping `enable` before the first rising edge of a frame abandons it. A frame already being clocked completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows polling and frame reads |
| selBusy | input | 1 | 0: poll the data line; 1: poll the busy line |
| sdoIn | input | 1 | Serial data / end-of-conversion line from the converter |
| busyIn | input | 1 | Busy line from the converter (high while converting) |
| sckOut | output | 1 | Serial clock to the converter, idles low |
| frameData | output | FRAME_BITS | Last captured frame, bit 31 is the flag bit |
| frameValid | output | 1 | One-cycle strobe when a new frame is in `frameData` |
| frameErr | output | 1 | Captured flag bit of the last frame was not 0 |
| timeoutFlag | output | 1 | Converter not ready within `TIMEOUT_CYC` polling cycles |
| waiting | output | 1 | High while polling for the ready level |

## Verification
Several properties are checked on every cycle:
- The clock edge count per frame.
- The minimum low and high phase lengths of the serial clock.
- The single-cycle strobe.
- The rule that the clock stays quiet while the converter is busy or the reader is disabled.
- The rule that a timeout can only arise while the ready line is high.

Other behaviours can only be shown by the bench scenarios, which use a converter model:
- The bit order and the content of the captured word.
- The error flag on a faulty flag bit.
- Selection between the data line and the busy line.
- The length of the timeout window.
- Resumption after `enable` is toggled.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_DONE
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrDiv;
    logic clrBits;
    logic capture;
    logic load;
    logic countPoll;
    logic clrTimeout;
  } rdStrobe_t;

endpackage

// File: rtl/rdr_datapath.sv
module rdr_datapath
  import rdr_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int FRAME_BITS  = 32,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rdStrobe_t             strb,
  input  logic                  sdoIn,
  input  logic                  busyIn,
  input  logic                  selBusy,
  output logic                  divTick,
  output logic                  lastBit,
  output logic                  readyNow,
  output logic [FRAME_BITS-1:0] frameData,
  output logic                  frameValid,
  output logic                  frameErr,
  output logic                  timeoutFlag
);

  localparam int BIT_W = $clog2(FRAME_BITS + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);

  logic [BIT_W-1:0]      bitCnt;
  logic [TO_W-1:0]       pollCnt;
  logic [FRAME_BITS-1:0] shiftReg;

  // ready level: 0 on the chosen line means result available
  assign readyNow = selBusy ? !busyIn : !sdoIn;
  assign lastBit  = (bitCnt == BIT_W'(FRAME_BITS));

  // half-period divider
  generate
    if (HALF_DIV == 1) begin : g_divOne
      assign divTick = 1'b1;
    end else begin : g_divCnt
      localparam int DIV_W = $clog2(HALF_DIV);
      logic [DIV_W-1:0] divCnt;
      assign divTick = (divCnt == DIV_W'(HALF_DIV - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 divCnt <= '0;
        else if (strb.clrDiv)      divCnt <= '0;
        else if (divTick)          divCnt <= '0;
        else                       divCnt <= divCnt + 1'b1;
      end
    end
  endgenerate

  // bit counter and shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (strb.clrBits) begin
      bitCnt   <= '0;
    end else if (strb.capture) begin
      bitCnt   <= bitCnt + 1'b1;
      shiftReg <= {shiftReg[FRAME_BITS-2:0], sdoIn};
    end
  end

  // output frame register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameData  <= '0;
      frameErr   <= 1'b0;
      frameValid <= 1'b0;
    end else begin
      frameValid <= strb.load;
      if (strb.load) begin
        frameData <= shiftReg;
        frameErr  <= shiftReg[FRAME_BITS-1];
      end
    end
  end

  // readiness timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt     <= '0;
      timeoutFlag <= 1'b0;
    end else if (strb.clrTimeout) begin
      pollCnt     <= '0;
      timeoutFlag <= 1'b0;
    end else if (strb.countPoll) begin
      if (pollCnt == TO_W'(TIMEOUT_CYC - 1)) begin
        pollCnt     <= '0;
        timeoutFlag <= 1'b1;
      end else begin
        pollCnt <= pollCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rdr_control.sv
module rdr_control
  import rdr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      readyNow,
  input  logic      divTick,
  input  logic      lastBit,
  output rdStrobe_t strb,
  output logic      sckOut,
  output logic      waiting
);

  rdState_t st, nxt;

  always_comb begin
    nxt         = st;
    strb        = '0;
    strb.clrDiv = (st == ST_IDLE) || (st == ST_POLL) || (st == ST_DONE);
    unique case (st)
      ST_IDLE: begin
        strb.clrBits    = 1'b1;
        strb.clrTimeout = 1'b1;
        if (enable) nxt = ST_POLL;
      end
      ST_POLL: begin
        if (!enable) begin
          nxt             = ST_IDLE;
          strb.clrTimeout = 1'b1;
        end else if (readyNow) begin
          nxt             = ST_SETUP;
          strb.clrBits    = 1'b1;
          strb.clrTimeout = 1'b1;
        end else begin
          strb.countPoll  = 1'b1;
        end
      end
      ST_SETUP: begin
        if (!enable) begin
          nxt = ST_IDLE;
        end else if (divTick) begin
          nxt          = ST_HIGH;
          strb.capture = 1'b1;
        end
      end
      ST_HIGH: begin
        if (divTick) begin
          if (lastBit) begin
            nxt       = ST_DONE;
            strb.load = 1'b1;
          end else begin
            nxt = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        if (divTick) begin
          nxt          = ST_HIGH;
          strb.capture = 1'b1;
        end
      end
      ST_DONE: nxt = enable ? ST_POLL : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      sckOut <= 1'b0;
    end else begin
      st     <= nxt;
      sckOut <= (nxt == ST_HIGH);
    end
  end

  assign waiting = (st == ST_POLL);

endmodule

// File: rtl/twowire_result_reader.sv
module twowire_result_reader
  import rdr_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int FRAME_BITS  = 32,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  selBusy,
  input  logic                  sdoIn,
  input  logic                  busyIn,
  output logic                  sckOut,
  output logic [FRAME_BITS-1:0] frameData,
  output logic                  frameValid,
  output logic                  frameErr,
  output logic                  timeoutFlag,
  output logic                  waiting
);

  rdStrobe_t strb;
  logic      divTick;
  logic      lastBit;
  logic      readyNow;

  rdr_control i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .readyNow (readyNow),
    .divTick  (divTick),
    .lastBit  (lastBit),
    .strb     (strb),
    .sckOut   (sckOut),
    .waiting  (waiting)
  );

  rdr_datapath #(
    .HALF_DIV    (HALF_DIV),
    .FRAME_BITS  (FRAME_BITS),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .sdoIn       (sdoIn),
    .busyIn      (busyIn),
    .selBusy     (selBusy),
    .divTick     (divTick),
    .lastBit     (lastBit),
    .readyNow    (readyNow),
    .frameData   (frameData),
    .frameValid  (frameValid),
    .frameErr    (frameErr),
    .timeoutFlag (timeoutFlag)
  );

endmodule

// File: rtl/rdr_checker.sv
module rdr_checker #(
  parameter int HALF_DIV   = 4,
  parameter int FRAME_BITS = 32
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic selBusy,
  input logic sdoIn,
  input logic busyIn,
  input logic sckOut,
  input logic frameValid,
  input logic timeoutFlag
);

  logic        readyLine;
  logic        sckQ;
  logic        frameOpen;
  logic [31:0] riseCnt;
  logic [31:0] lowLen;
  logic [31:0] highLen;

  assign readyLine = selBusy ? busyIn : sdoIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ      <= 1'b0;
      frameOpen <= 1'b0;
      riseCnt   <= '0;
      lowLen    <= '0;
      highLen   <= '0;
    end else begin
      sckQ <= sckOut;
      if (frameValid)            riseCnt <= '0;
      else if (sckOut && !sckQ)  riseCnt <= riseCnt + 1;
      if (sckOut) lowLen  <= '0; else lowLen  <= lowLen + 1;
      if (sckOut) highLen <= highLen + 1; else highLen <= '0;
      if (sckOut && !sckQ)       frameOpen <= 1'b1;
      else if (frameValid)       frameOpen <= 1'b0;
    end
  end

  // R5: exact edge count per frame
  assert_edge_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> riseCnt == 32'(FRAME_BITS));

  // R4: low phase length before each rising edge
  assert_low_phase_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sckOut && !sckQ) |-> lowLen >= 32'(HALF_DIV));

  // R4: high phase length before each falling edge
  assert_high_phase_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!sckOut && sckQ) |-> highLen == 32'(HALF_DIV));

  // R7: single-cycle strobe
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  // R2: no clocking while the converter reports busy
  assert_quiet_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!frameOpen && !sckOut && readyLine) |=> !sckOut);

  // R10: no new frame starts while disabled
  assert_quiet_disabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !frameOpen && !sckOut) |=> !sckOut);

  // R9: timeout only arises from polling a busy line
  assert_timeout_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(readyLine));

endmodule

bind twowire_result_reader rdr_checker #(
  .HALF_DIV   (HALF_DIV),
  .FRAME_BITS (FRAME_BITS)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .selBusy     (selBusy),
  .sdoIn       (sdoIn),
  .busyIn      (busyIn),
  .sckOut      (sckOut),
  .frameValid  (frameValid),
  .timeoutFlag (timeoutFlag)
);

// File: tb/test_twowire_result_reader.sv
module test_twowire_result_reader;

  localparam int HALF_DIV    = 3;
  localparam int FRAME_BITS  = 32;
  localparam int TIMEOUT_CYC = 64;

  typedef struct packed {
    logic [31:0] word;
    logic [15:0] lat;
    logic        sel;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{32'h0ABC_1234, 16'd10, 1'b0},
    '{32'h7FFF_FFFF, 16'd6,  1'b0},
    '{32'h0000_0001, 16'd25, 1'b0},
    '{32'h5A5A_A5A5, 16'd7,  1'b1},
    '{32'hC000_00FF, 16'd9,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        selBusy = 1'b0;
  logic        sdoIn;
  logic        busyIn;
  logic        sckOut;
  logic [31:0] frameData;
  logic        frameValid;
  logic        frameErr;
  logic        timeoutFlag;
  logic        waiting;

  int testCnt = 0;
  int failCnt = 0;
  int cyc = 0;

  // converter model state
  logic [31:0] curWord = 32'h0;
  int          curLat  = 5;
  logic        converting;
  logic        sckPrev;
  logic        risen;
  int          latCnt;
  int          bitIdx;
  int          riseCnt;
  int          badRise;
  int          gapCnt;
  int          lastGap;

  always #4 clk = ~clk;  // 125 MHz

  twowire_result_reader #(
    .HALF_DIV    (HALF_DIV),
    .FRAME_BITS  (FRAME_BITS),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) i_twowire_result_reader (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .selBusy     (selBusy),
    .sdoIn       (sdoIn),
    .busyIn      (busyIn),
    .sckOut      (sckOut),
    .frameData   (frameData),
    .frameValid  (frameValid),
    .frameErr    (frameErr),
    .timeoutFlag (timeoutFlag),
    .waiting     (waiting)
  );

  // behavioural converter: shifts on falling sck, restarts after 32nd fall
  always @(posedge clk) begin
    sckPrev <= sckOut;
    if (!rstN) begin
      converting <= 1'b1;
      sdoIn      <= 1'b1;
      busyIn     <= 1'b1;
      latCnt     <= 0;
      bitIdx     <= 0;
      riseCnt    <= 0;
      badRise    <= 0;
      gapCnt     <= 0;
      lastGap    <= 0;
      risen      <= 1'b0;
      sckPrev    <= 1'b0;
    end else begin
      if (!sckPrev && sckOut) begin
        riseCnt <= riseCnt + 1;
        if (converting) badRise <= badRise + 1;
        if (!converting && !risen) begin
          risen   <= 1'b1;
          lastGap <= gapCnt;
        end
      end else if (!converting && !risen) begin
        gapCnt <= gapCnt + 1;
      end
      if (converting) begin
        if (latCnt >= curLat) begin
          converting <= 1'b0;
          busyIn     <= 1'b0;
          sdoIn      <= curWord[31];
          bitIdx     <= 0;
          riseCnt    <= 0;
          gapCnt     <= 0;
          risen      <= 1'b0;
        end else begin
          latCnt <= latCnt + 1;
        end
      end else if (sckPrev && !sckOut) begin
        if (bitIdx == 31) begin
          converting <= 1'b1;
          latCnt     <= 0;
          sdoIn      <= 1'b1;
          busyIn     <= 1'b1;
        end else begin
          sdoIn  <= curWord[30-bitIdx];
          bitIdx <= bitIdx + 1;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitValid(input string req);
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (frameValid) break;
    end
    check(req, {31'b0, frameValid}, 32'd1);
  endtask

  task automatic runCycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failCnt++;
      $display("FAIL R5 watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    curWord = VEC[0].word;
    curLat  = 5;
    runCycles(5);
    // R1: reset state
    check("R1 sck", {31'b0, sckOut}, 32'd0);
    check("R1 valid", {31'b0, frameValid}, 32'd0);
    check("R1 data", frameData, 32'd0);
    check("R1 err", {31'b0, frameErr}, 32'd0);
    check("R1 timeout", {31'b0, timeoutFlag}, 32'd0);
    rstN = 1'b1;

    // R10: disabled reader leaves a ready converter alone
    runCycles(40);
    check("R10 no edges while disabled", riseCnt, 32'd0);
    check("R10 not polling", {31'b0, waiting}, 32'd0);
    enable = 1'b1;

    // table of frames
    for (int i = 0; i < NVEC; i++) begin
      selBusy = VEC[i].sel;
      curWord = VEC[i].word;
      curLat  = int'(VEC[i].lat);
      waitValid("R7 frame strobe");
      check("R6 frame data", frameData, VEC[i].word);
      check("R8 flag bit error", {31'b0, frameErr}, {31'b0, VEC[i].word[31]});
      check("R5 rising edges", riseCnt, 32'd32);
      check("R4 setup gap", {31'b0, (lastGap >= HALF_DIV)}, 32'd1);
      check("R2 no edges while busy", badRise, 32'd0);
      if (i == NVEC - 1) begin
        // prepare slow conversion for the timeout test (R3 data-line mode again)
        curLat  = 400;
        curWord = 32'h0123_4567;
        selBusy = 1'b0;
      end
      @(negedge clk);
      check("R7 single cycle", {31'b0, frameValid}, 32'd0);
      check("R7 data held", frameData, VEC[i].word);
    end

    // R9: timeout window
    runCycles(28);
    check("R9 flag low early", {31'b0, timeoutFlag}, 32'd0);
    runCycles(90);
    check("R9 flag after window", {31'b0, timeoutFlag}, 32'd1);
    check("R3 polling data line", {31'b0, waiting}, 32'd1);
    waitValid("R9 frame after timeout");
    check("R9 flag cleared", {31'b0, timeoutFlag}, 32'd0);
    check("R6 slow frame", frameData, 32'h0123_4567);

    // R10: drop enable after a frame, then resume
    enable  = 1'b0;
    curLat  = 5;
    curWord = 32'h0F0F_3C3C;
    runCycles(80);
    check("R10 idle edges", riseCnt, 32'd0);
    check("R10 no strobe", frameData, 32'h0123_4567);
    enable = 1'b1;
    waitValid("R10 resume");
    check("R10 resumed data", frameData, 32'h0F0F_3C3C);
    check("R2 totals", badRise, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule